// File: doc/BRIEF.md
# Modem Line Status Register with Change Flags

This block watches four active-low modem handshake lines (clear-to-send, data-set-ready, ring indicator and carrier detect) and presents them to a host as one 8-bit status byte. The high nibble gives the present level of each line, converted to active-high. The low nibble holds sticky flags that record a change on each line since the host last read the byte. A host read clears every flag.

Each external line passes through a synchronizer before any edge is detected. A loopback control swaps the four external lines for four bits of a modem control register, so software can drive the status path without outside wiring. Any set flag raises an interrupt request when the modem-status interrupt enable is high. Baud timing, data FIFOs and interrupt prioritising are handled elsewhere.

Top module: `modem_status_reg`

## Requirements
- R1: Lines are active low. Each status bit 4..7 is the inverse of its synchronized pin. A pin change shows in the status byte at the third rising edge after the change (two synchronizer flops, then the status register).
- R2: Status bit 4 is clear-to-send, bit 5 is data-set-ready, bit 6 is ring indicator and bit 7 is carrier detect. The pin vector `line_n_i` uses lanes 0..3 in that same order.
- R3: Flag bits 0 (clear-to-send), 1 (data-set-ready) and 3 (carrier detect) set on any change of the matching status bit, in either direction. The flag appears one edge after the status bit changes.
- R4: Flag bit 2 sets only when status bit 6 rises from 0 to 1. A fall of status bit 6 leaves flag bit 2 unchanged.
- R5: Flags stay set until a read. `rd_i` high in a cycle clears all four flags at that cycle's closing edge.
- R6: If a line change would set a flag at the same edge that a read clears it, the flag stays set.
- R7: With `loop_en_i` high, control bit 1 drives clear-to-send, bit 0 drives data-set-ready, bit 2 drives ring indicator and bit 3 drives carrier detect. These bits are active high and show in the status byte at the next edge. The external pins are ignored.
- R8: Entering or leaving loopback counts as an ordinary line change. The flags set wherever the observed value differs.
- R9: `irq_o` is high exactly when `irq_en_i` is high and any flag bit 0..3 is set.
- R10: A synchronous active-high reset clears all flags. While reset is held, the status high nibble follows the current line values (the inverted pins, or the control bits in loopback). Leaving reset causes no spurious flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_n_i | input | 4 | Active-low lines: [0] clear-to-send, [1] data-set-ready, [2] ring, [3] carrier |
| loop_en_i | input | 1 | Loopback select |
| mctl_i | input | 4 | Modem control register bits used in loopback |
| rd_i | input | 1 | Host read strobe for the status byte |
| irq_en_i | input | 1 | Modem-status interrupt enable |
| status_o | output | 8 | Status byte: [7:4] line levels, [3:0] change flags |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that the read strobe lasts one cycle per host access. They also assume that the loopback select and control bits change only at clock edges, so the one-edge loopback path can be related to their sampled values. The stimulus drives all inputs just after the falling edge. Pins change at random intervals and often overlap with reads, loopback switches and enable toggles. This keeps the properties inside their assumptions while still reaching the read-versus-change collision and falling ring edges.

// File: rtl/msr_pkg.sv
package msr_pkg;
   localparam int unsigned MSR_LANES    = 4;
   localparam int unsigned LANE_CTS     = 0;
   localparam int unsigned LANE_DSR     = 1;
   localparam int unsigned LANE_RING    = 2;
   localparam int unsigned LANE_CARRIER = 3;

   typedef logic [MSR_LANES-1:0] lane_vec_t;

   // Maps modem control bits onto status lanes for loopback
   function automatic lane_vec_t loop_route(input lane_vec_t ctl);
      lane_vec_t r;
      r[LANE_CTS]     = ctl[1];
      r[LANE_DSR]     = ctl[0];
      r[LANE_RING]    = ctl[2];
      r[LANE_CARRIER] = ctl[3];
      return r;
   endfunction
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("msr_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("msr_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < int'(STAGES); k++) stage_q[k] <= d_i;
      end else begin
         stage_q[0] <= d_i;
         for (int k = 1; k < int'(STAGES); k++) stage_q[k] <= stage_q[k-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/msr_delta.sv
module msr_delta #(
   parameter int unsigned WIDTH     = 4,
   parameter logic [WIDTH-1:0] RISE_MASK = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] obs_i,
   input  logic             clr_i,
   output logic [WIDTH-1:0] cur_o,
   output logic [WIDTH-1:0] delta_o
);
   logic [WIDTH-1:0] cur_q, prv_q, delta_q, ev;

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_q   <= obs_i;
         prv_q   <= obs_i;
         delta_q <= '0;
      end else begin
         prv_q   <= cur_q;
         cur_q   <= obs_i;
         delta_q <= (delta_q & ~{WIDTH{clr_i}}) | ev;
      end
   end

   for (genvar i = 0; i < int'(WIDTH); i++) begin : g_lane
      if (RISE_MASK[i]) begin : g_rise
         assign ev[i] = cur_q[i] & ~prv_q[i];

         p_fall_ignored_r4: assert property (@(posedge clk) disable iff (rst)
            (!delta_q[i] && prv_q[i] && !cur_q[i]) |=> !delta_q[i]);
         p_rise_kept_r6: assert property (@(posedge clk) disable iff (rst)
            (cur_q[i] && !prv_q[i]) |=> delta_q[i]);
      end else begin : g_any
         assign ev[i] = cur_q[i] ^ prv_q[i];

         p_edge_kept_r6: assert property (@(posedge clk) disable iff (rst)
            (cur_q[i] != prv_q[i]) |=> delta_q[i]);
      end

      p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
         (delta_q[i] && !clr_i) |=> delta_q[i]);
      p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
         (clr_i && cur_q[i] == prv_q[i]) |=> !delta_q[i]);
   end

   assign cur_o   = cur_q;
   assign delta_o = delta_q;
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg #(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter logic [3:0]  RISE_ONLY_MASK = 4'b0100
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [3:0] line_n_i,
   input  logic       loop_en_i,
   input  logic [3:0] mctl_i,
   input  logic       rd_i,
   input  logic       irq_en_i,
   output logic [7:0] status_o,
   output logic       irq_o
);
   import msr_pkg::*;
   localparam int unsigned LANES = MSR_LANES;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("modem_status_reg: SYNC_STAGES must be at least 2");
      end
   endgenerate

   lane_vec_t pins_sync, obs, cur, delta;

   msr_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (line_n_i),
      .q_o (pins_sync)
   );

   // Loopback takes priority; during reset the raw pins seed the state
   always_comb begin
      if (loop_en_i)  obs = loop_route(mctl_i);
      else if (rst)   obs = ~line_n_i;
      else            obs = ~pins_sync;
   end

   msr_delta #(.WIDTH(LANES), .RISE_MASK(RISE_ONLY_MASK)) u_delta (
      .clk     (clk),
      .rst     (rst),
      .obs_i   (obs),
      .clr_i   (rd_i),
      .cur_o   (cur),
      .delta_o (delta)
   );

   assign status_o = {cur, delta};
   assign irq_o    = irq_en_i & (|delta);

   p_loop_cts_r7: assert property (@(posedge clk) disable iff (rst)
      loop_en_i |=> status_o[4] == $past(mctl_i[1]));
   p_loop_cd_r7: assert property (@(posedge clk) disable iff (rst)
      loop_en_i |=> status_o[7] == $past(mctl_i[3]));
   p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
      !irq_en_i |-> !irq_o);
   p_irq_after_read_r9: assert property (@(posedge clk) disable iff (rst)
      (rd_i && $stable(status_o[7:4]) && status_o[7:4] == $past(status_o[7:4])) |=> !irq_o);
endmodule

// File: tb/modem_status_reg_bench.sv
module modem_status_reg_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] line_n_i = 4'hF;
   logic       loop_en_i = 1'b0;
   logic [3:0] mctl_i = 4'h0;
   logic       rd_i = 1'b0;
   logic       irq_en_i = 1'b0;
   logic [7:0] status_o;
   logic       irq_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   modem_status_reg u_modem_status_reg (
      .clk(clk), .rst(rst), .line_n_i(line_n_i), .loop_en_i(loop_en_i),
      .mctl_i(mctl_i), .rd_i(rd_i), .irq_en_i(irq_en_i),
      .status_o(status_o), .irq_o(irq_o)
   );

   // Behavioural reference state
   int m_s1, m_s2, m_cur, m_prv, m_flag;

   function automatic int routed(input int c);
      return (((c >> 1) & 1) << 0) | ((c & 1) << 1) | (((c >> 2) & 1) << 2) | (((c >> 3) & 1) << 3);
   endfunction

   task automatic model_step();
      int seen, ev, nxt;
      if (rst) begin
         m_s1 = line_n_i; m_s2 = line_n_i;
         seen = loop_en_i ? routed(mctl_i) : (~int'(line_n_i)) & 15;
         m_cur = seen; m_prv = seen; m_flag = 0;
      end else begin
         seen = loop_en_i ? routed(mctl_i) : (~m_s2) & 15;
         ev = (m_cur ^ m_prv) & 4'b1011;
         if (((m_cur >> 2) & 1) == 1 && ((m_prv >> 2) & 1) == 0) ev = ev | 4;
         nxt = (rd_i ? 0 : m_flag) | ev;
         m_s2 = m_s1; m_s1 = line_n_i;
         m_prv = m_cur; m_cur = seen; m_flag = nxt;
      end
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   task automatic compare_all();
      int lvl, fl, irq_exp;
      lvl = int'(status_o[7:4]);
      fl  = int'(status_o[3:0]);
      irq_exp = (irq_en_i && m_flag != 0) ? 1 : 0;
      check(lvl == m_cur, "R1 R2 R7 line levels", lvl, m_cur);
      check((fl & 4'b1011) == (m_flag & 4'b1011), "R3 R5 R6 R8 change flags", fl, m_flag);
      check(((fl >> 2) & 1) == ((m_flag >> 2) & 1), "R4 ring flag", fl, m_flag);
      check(int'(irq_o) == irq_exp, "R9 interrupt", int'(irq_o), irq_exp);
   endtask

   task automatic cycle();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      // Reset with clear-to-send and carrier asserted (pins low)
      line_n_i = 4'b0110;
      repeat (4) cycle();
      rst = 1'b0;
      cycle();
      check(status_o == 8'h90, "R10 reset state", int'(status_o), 8'h90);

      // Ring pin falls (status rises) then returns: only the rise flags
      irq_en_i = 1'b1;
      line_n_i = 4'b0010;
      repeat (5) cycle();
      check(status_o[2] == 1'b1, "R4 ring rise flagged", int'(status_o), 8'hD4);
      rd_i = 1'b1; cycle(); rd_i = 1'b0;
      check(status_o[3:0] == 4'h0, "R5 read clears", int'(status_o), 8'hD0);
      line_n_i = 4'b0110;
      repeat (5) cycle();
      check(status_o[2] == 1'b0, "R4 ring fall ignored", int'(status_o), 8'h90);

      // Read collides with a new data-set-ready edge
      line_n_i = 4'b0100;
      cycle(); cycle(); cycle();
      rd_i = 1'b1; cycle(); rd_i = 1'b0;
      check(status_o[1] == 1'b1, "R6 change during read kept", int'(status_o), 8'hB2);

      // Loopback entry with all control bits set, pins ignored
      rd_i = 1'b1; cycle(); rd_i = 1'b0;
      loop_en_i = 1'b1; mctl_i = 4'hF;
      cycle(); cycle();
      check(status_o[7:4] == 4'hF, "R7 loopback levels", int'(status_o), 8'hF4);
      line_n_i = 4'b1111;
      repeat (4) cycle();
      check(status_o[7:4] == 4'hF, "R7 pins ignored in loopback", int'(status_o), 8'hF4);
      check(status_o[2] == 1'b1, "R8 loopback switch flags ring", int'(status_o), 8'hF4);
      irq_en_i = 1'b0; cycle();
      check(irq_o == 1'b0, "R9 disabled interrupt", int'(irq_o), 0);
      loop_en_i = 1'b0; mctl_i = 4'h0;

      // Random traffic against the reference
      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(0, 5) == 0) line_n_i = 4'($urandom);
         rd_i = ($urandom_range(0, 6) == 0);
         if ($urandom_range(0, 40) == 0) loop_en_i = ~loop_en_i;
         if ($urandom_range(0, 8) == 0) mctl_i = 4'($urandom);
         if ($urandom_range(0, 30) == 0) irq_en_i = ~irq_en_i;
         if ($urandom_range(0, 700) == 0) rst = 1'b1; else rst = 1'b0;
         cycle();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired at %0t: actual=running expected=done", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule